// File: doc/BRIEF.md
# Interrupt Vector Fetch Unit

This unit turns a pending request from the reset, trap, non-maskable or user interrupt lines into the 24-bit start address of its service routine. It picks the request with the highest priority and works out where that request's entry sits in a fixed table in program memory. It then reads the four bytes of that entry over a byte-wide synchronous read port. The first byte must be a marker opcode. The other three bytes form the routine address, most significant byte first.

If the marker matches, the unit gives a one-cycle done pulse that carries the assembled target and the entry index. If the marker does not match, the byte counts as an illegal opcode, and the unit gives a one-cycle reset-request pulse in place of a target. Requests are taken only while the unit is idle. Stacking the context and masking levels are left to the surrounding core.

Top module: `irq_vector_fetch`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it, `done`, `resetReq` and `memRd` are 0, and `target` and `entryIdx` read 0.
- R2: Bit 0 of `reqLines` is reset, bit 1 is trap, bit 2 is non-maskable, and bit 3+k is user interrupt k (k = 0..28). When several bits are set, the lowest-numbered bit wins, and its number is the entry index.
- R3: Entry n starts at byte address 0x008000 + 4*n, so user interrupt 28 starts at 0x00807C. The unit reads offsets 0, 1, 2 and 3 of the entry on four consecutive cycles, with `memRd` high.
- R4: Memory data for an address is taken from `memData` one cycle after the address is presented.
- R5: When byte 0 of the entry equals 0x82, `target` is {byte1, byte2, byte3}. Byte 1 is the most significant byte, then byte 2, then byte 3 as the least significant byte.
- R6: When byte 0 is any value other than 0x82, `resetReq` pulses for one cycle, `done` stays 0, and `target` keeps its previous value.
- R7: `done` and `resetReq` are never high together. Each lasts exactly one cycle, and `entryIdx` then shows the index that was served.
- R8: Requests are sampled only while the unit is idle. Changing `reqLines` during a fetch does not change the addresses it reads or the index it reports.
- R9: If a request is sampled at clock edge k, the first read address appears after edge k, and the result pulse appears after edge k+5.
- R10: With no request pending, `memRd` stays 0 and no result pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqLines | input | 32 | Pending request per table entry (bit 0 = reset) |
| memRd | output | 1 | Program memory read strobe |
| memAddr | output | 24 | Program memory byte address |
| memData | input | 8 | Read data, valid one cycle after the address |
| done | output | 1 | One-cycle pulse: target is valid |
| resetReq | output | 1 | One-cycle pulse: marker was not the expected opcode |
| target | output | 24 | Assembled service routine address |
| entryIdx | output | 5 | Table index that was served |

## Verification
A request is sampled at edge k. The four read addresses are then due in the cycles after edges k through k+3. The strobe is low after edge k+4, the result pulse is due after edge k+5, and it is gone after edge k+6. Each scenario task drives its inputs on the falling edge and then steps one falling edge at a time. At every step it compares the port values due in that cycle, so a result that arrives one cycle early or late fails at the exact step where it was expected.

// File: rtl/vf_pkg.sv
`timescale 1ns/1ps
package vf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ0,
    ST_READ1,
    ST_READ2,
    ST_READ3,
    ST_DONE
  } vfState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic       latchReq;
    logic       rd;
    logic [1:0] byteSel;
    logic       capMarker;
    logic       capExt;
    logic       capHigh;
    logic       finish;
  } vfStrobe_t;

endpackage

// File: rtl/vf_ctrl.sv
`timescale 1ns/1ps
module vf_ctrl
  import vf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      anyReq,
  output vfStrobe_t strb
);

  vfState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        strb.latchReq = anyReq;
        if (anyReq) stateNext = ST_READ0;
      end
      ST_READ0: begin
        strb.rd      = 1'b1;
        strb.byteSel = 2'd0;
        stateNext    = ST_READ1;
      end
      ST_READ1: begin
        strb.rd        = 1'b1;
        strb.byteSel   = 2'd1;
        strb.capMarker = 1'b1;
        stateNext      = ST_READ2;
      end
      ST_READ2: begin
        strb.rd      = 1'b1;
        strb.byteSel = 2'd2;
        strb.capExt  = 1'b1;
        stateNext    = ST_READ3;
      end
      ST_READ3: begin
        strb.rd      = 1'b1;
        strb.byteSel = 2'd3;
        strb.capHigh = 1'b1;
        stateNext    = ST_DONE;
      end
      ST_DONE: begin
        strb.finish = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R8
  start_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ0) |-> ($past(anyReq) && $past(state) == ST_IDLE));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !$past(anyReq)) |-> !strb.rd);

endmodule

// File: rtl/vf_datapath.sv
`timescale 1ns/1ps
module vf_datapath
  import vf_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned IDX_W       = 5,
  parameter int unsigned TABLE_BASE  = 32'h0000_8000,
  parameter int unsigned MARKER      = 32'h82
) (
  input  logic                   clk,
  input  logic                   rst,
  input  vfStrobe_t              strb,
  input  logic [NUM_ENTRIES-1:0] reqLines,
  input  logic [DATA_W-1:0]      memData,
  output logic                   anyReq,
  output logic                   memRd,
  output logic [ADDR_W-1:0]      memAddr,
  output logic                   done,
  output logic                   resetReq,
  output logic [ADDR_W-1:0]      target,
  output logic [IDX_W-1:0]       entryIdx
);

  localparam int unsigned PAD_W    = ADDR_W - IDX_W - 2;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(TABLE_BASE);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(TABLE_BASE + 4 * NUM_ENTRIES);
  localparam logic [DATA_W-1:0] MARK_B = DATA_W'(MARKER);

  logic [IDX_W-1:0]  winner;
  logic [IDX_W-1:0]  idxQ;
  logic              markerOkQ;
  logic [DATA_W-1:0] extQ, highQ;

  // lowest-numbered pending line wins
  always_comb begin
    winner = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (reqLines[i]) winner = IDX_W'(i);
    end
  end

  assign anyReq  = |reqLines;
  assign memRd   = strb.rd;
  assign memAddr = BASE_A + {{PAD_W{1'b0}}, idxQ, strb.byteSel};

  always_ff @(posedge clk) begin
    if (rst) begin
      idxQ      <= '0;
      markerOkQ <= 1'b0;
      extQ      <= '0;
      highQ     <= '0;
    end else begin
      if (strb.latchReq)  idxQ      <= winner;
      if (strb.capMarker) markerOkQ <= (memData == MARK_B);
      if (strb.capExt)    extQ      <= memData;
      if (strb.capHigh)   highQ     <= memData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      resetReq <= 1'b0;
      target   <= '0;
      entryIdx <= '0;
    end else begin
      done     <= strb.finish &  markerOkQ;
      resetReq <= strb.finish & ~markerOkQ;
      if (strb.finish) entryIdx <= idxQ;
      if (strb.finish && markerOkQ) target <= {extQ, highQ, memData};
    end
  end

  // R3
  read_in_table_chk: assert property (@(posedge clk) disable iff (rst)
    memRd |-> (memAddr >= BASE_A && memAddr < END_A));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (memRd && $past(memRd)) |-> (memAddr == $past(memAddr) + 1'b1));

  // R7
  one_result_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, resetReq}));

  // R9
  result_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (done || resetReq) |-> ($past(memRd, 2) && !$past(memRd, 1)));

  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    (done || resetReq) |=> !(done || resetReq));

endmodule

// File: rtl/irq_vector_fetch.sv
`timescale 1ns/1ps
module irq_vector_fetch
  import vf_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned TABLE_BASE  = 32'h0000_8000,
  parameter int unsigned MARKER      = 32'h82,
  localparam int unsigned ADDR_W     = 3 * DATA_W,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_ENTRIES-1:0] reqLines,
  output logic                   memRd,
  output logic [ADDR_W-1:0]      memAddr,
  input  logic [DATA_W-1:0]      memData,
  output logic                   done,
  output logic                   resetReq,
  output logic [ADDR_W-1:0]      target,
  output logic [IDX_W-1:0]       entryIdx
);

  vfStrobe_t strb;
  logic      anyReq;

  vf_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .anyReq (anyReq),
    .strb   (strb)
  );

  vf_datapath #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .NUM_ENTRIES (NUM_ENTRIES),
    .IDX_W       (IDX_W),
    .TABLE_BASE  (TABLE_BASE),
    .MARKER      (MARKER)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .reqLines (reqLines),
    .memData  (memData),
    .anyReq   (anyReq),
    .memRd    (memRd),
    .memAddr  (memAddr),
    .done     (done),
    .resetReq (resetReq),
    .target   (target),
    .entryIdx (entryIdx)
  );

endmodule

// File: tb/sim_irq_vector_fetch.sv
`timescale 1ns/1ps
module sim_irq_vector_fetch;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] reqLines = '0;
  logic        memRd;
  logic [23:0] memAddr;
  logic [7:0]  memData = '0;
  logic        done;
  logic        resetReq;
  logic [23:0] target;
  logic [4:0]  entryIdx;

  int total = 0;
  int bad   = 0;
  logic [31:0] badMarkMask = '0;

  always #2 clk = ~clk;

  irq_vector_fetch u0 (
    .clk(clk), .rst(rst), .reqLines(reqLines), .memRd(memRd),
    .memAddr(memAddr), .memData(memData), .done(done),
    .resetReq(resetReq), .target(target), .entryIdx(entryIdx)
  );

  function automatic logic [7:0] tblByte(input logic [23:0] a);
    logic [23:0] off;
    int idx;
    off = a - 24'h008000;
    if (a < 24'h008000 || off >= 24'd128) return 8'hFF;
    idx = int'(off >> 2);
    case (off[1:0])
      2'd0: return badMarkMask[idx] ? 8'h9D : 8'h82;
      2'd1: return 8'(idx * 3 + 1);
      2'd2: return 8'hC0 ^ 8'(idx);
      default: return 8'(idx * 7 + 5);
    endcase
  endfunction

  function automatic logic [23:0] expTarget(input int idx);
    return {8'(idx * 3 + 1), 8'hC0 ^ 8'(idx), 8'(idx * 7 + 5)};
  endfunction

  // R4: memory model, data one cycle after address
  always @(posedge clk) if (memRd) memData <= tblByte(memAddr);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // request sampled at edge k; reqDuring is driven during the fetch
  task automatic doFetch(input string req, input logic [31:0] reqVec,
                         input logic [31:0] reqDuring, input int expIdx,
                         input bit expBad, input logic [23:0] prevTarget);
    @(negedge clk);
    reqLines = reqVec;
    @(negedge clk);
    reqLines = reqDuring;
    for (int b = 0; b < 4; b++) begin
      chk(req, "memRd", memRd, 1);
      chk(req, "memAddr", memAddr, 24'h008000 + 24'(4 * expIdx + b));
      chk(req, "done early", done | resetReq, 0);
      @(negedge clk);
    end
    chk(req, "memRd after reads", memRd, 0);
    chk(req, "result early", done | resetReq, 0);
    @(negedge clk);
    reqLines = '0;
    chk(req, "done", done, !expBad);
    chk(req, "resetReq", resetReq, expBad);
    chk(req, "entryIdx", entryIdx, expIdx);
    chk(req, "target", target, expBad ? prevTarget : expTarget(expIdx));
    @(negedge clk);
    chk(req, "pulse end", done | resetReq, 0);
    chk(req, "idle after", memRd, 0);
  endtask

  task automatic tReset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", done, 0);
    chk("R1", "resetReq in reset", resetReq, 0);
    chk("R1", "memRd in reset", memRd, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "target", target, 0);
    chk("R1", "entryIdx", entryIdx, 0);
    chk("R1", "done", done, 0);
  endtask

  task automatic tIdle;
    reqLines = '0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk("R10", "memRd idle", memRd, 0);
      chk("R10", "no pulse", done | resetReq, 0);
    end
  endtask

  task automatic tSingles;
    doFetch("R2 reset", 32'h1, 0, 0, 0, 0);
    doFetch("R2 trap", 32'h2, 0, 1, 0, 0);
    doFetch("R2 nmi", 32'h4, 0, 2, 0, 0);
    doFetch("R3 user28", 32'h8000_0000, 0, 31, 0, 0);
    doFetch("R5 user5", 32'h1 << 8, 0, 8, 0, 0);
  endtask

  task automatic tPriority;
    doFetch("R2 multi", 32'hF000_0006, 0, 1, 0, 0);
    doFetch("R2 users", 32'h0010_0010, 0, 4, 0, 0);
  endtask

  task automatic tBadMarker;
    logic [23:0] prev;
    doFetch("R5 before", 32'h1 << 12, 0, 12, 0, 0);
    prev = expTarget(12);
    badMarkMask = 32'h1 << 20;
    doFetch("R6 bad", 32'h1 << 20, 0, 20, 1, prev);
    badMarkMask = '0;
  endtask

  task automatic tBusy;
    // R8: lower-index line raised mid-fetch must not redirect it
    doFetch("R8 busy", 32'h1 << 9, 32'h1, 9, 0, 0);
    tIdle();
  endtask

  initial begin
    tReset();
    tIdle();
    tSingles();
    tPriority();
    tBadMarker();
    tBusy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule